// File: doc/BRIEF.md
# Power-Up Reset Delay Sequencer

This block keeps a device in reset after power-on until the supply and the primary clock can be trusted. It runs on the primary oscillator clock. A slow, free-running internal reference clock is sampled as data, and its synchronized rising edges are used as timing ticks. Up to three stages run one after another: a power-up wait timed in reference ticks, an oscillator start-up wait timed in primary clock cycles, and a PLL lock wait timed in reference ticks. The oscillator mode code and the power-up enable decide which of these stages run. A controller-ready delay starts at each restart and runs alongside the stages.

The device reset output goes high only when the last stage has finished and the controller-ready delay has expired. It then passes through a two-flop stage before reaching the pin. A `por_i` pulse restarts the whole sequence at any point. The `stage_o` output reports which stage is active, so the power-up progress can be watched from outside.

Top module: `pwrup_seq`

## Requirements
- R1: While `rst_ni` is low, and after it rises until the first clock edge, `stage_o` is 0 (idle) and `dev_rst_no` is 0. Stage codes are: 0 idle, 1 power-up wait, 2 start-up count, 3 PLL wait, 4 done.
- R2: On the first clock edge after a restart, `pwrt_en_ni` and `osc_mode_i` are captured. Changes to them after that point have no effect on the sequence until the next restart.
- R3: When `pwrt_en_ni` is 0, stage 1 runs first. It lasts until `PWRT_TICKS` reference ticks have been counted. A tick is a rising edge of `ref_clk_i` seen through a two-flop synchronizer.
- R4: The crystal modes are `osc_mode_i` 0, 1, 2 and 3. In these modes stage 2 runs for exactly `OST_CYCLES` clock cycles. It starts only after stage 1 has finished or been skipped.
- R5: Mode 3 (crystal with PLL) adds stage 3 after stage 2. Stage 3 lasts `PLL_TICKS` reference ticks.
- R6: Modes 4 to 7 never enter stage 2 or stage 3. They go to stage 4 straight after stage 1. If stage 1 is disabled, they go to stage 4 one cycle after the restart.
- R7: A controller-ready delay of `READY_TICKS` reference ticks starts at each restart and runs in parallel with the stages. The reset is not released before this delay expires, even when stage 4 is reached earlier.
- R8: `dev_rst_no` rises two clock cycles after the first cycle in which stage 4 is active and the ready delay has expired. It then stays high until the next restart.
- R9: A `por_i` pulse at any time returns `stage_o` to 0 and `dev_rst_no` to 0 on the next edge. It clears all counts, and the full sequence then runs again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Primary oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| por_i | input | 1 | Power-on-reset pulse; restarts the sequence |
| ref_clk_i | input | 1 | Free-running low-frequency reference clock, sampled as data |
| pwrt_en_ni | input | 1 | Power-up timer enable, active low |
| osc_mode_i | input | 3 | Oscillator mode: 0-2 crystal, 3 crystal with PLL, 4-7 non-crystal |
| dev_rst_no | output | 1 | Device reset, active low; high means released |
| stage_o | output | 3 | Active stage code |

## Verification
The bench checks that the start-up stage lasts exactly the parameter count. An off-by-one counter would lengthen or shorten it by a cycle. It flips the mode and the enable in the middle of a sequence: a design that reads the mode live would jump out of the start-up stage. A non-crystal mode with the power-up timer disabled reaches stage 4 at once. That run checks that release still waits for the ready delay, which a design that gates release on the stage alone would fail. Restarts in the middle of the start-up count must clear both the stage and the reset output. A stale counter would show up as a shortened second sequence.

// File: rtl/pwrup_seq_pkg.sv
package pwrup_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PWRT = 3'd1,
    ST_OST  = 3'd2,
    ST_PLL  = 3'd3,
    ST_DONE = 3'd4
  } stage_e;

  localparam int MODE_W = 3;

  function automatic logic mode_is_xtal(input logic [MODE_W-1:0] m);
    return m <= 3'd3;
  endfunction

  function automatic logic mode_is_pll(input logic [MODE_W-1:0] m);
    return m == 3'd3;
  endfunction
endpackage

// File: rtl/pwrup_ref_tick.sv
module pwrup_ref_tick #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_clk_i,
  output logic tick_o
);
  logic [SYNC_STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[SYNC_STAGES-1:0], ref_clk_i};
  end

  // rising edge seen after the synchronizer
  assign tick_o = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
endmodule

// File: rtl/pwrup_ready_timer.sv
module pwrup_ready_timer #(
  parameter int READY_TICKS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  output logic ready_o
);
  localparam int RW = $clog2(READY_TICKS + 1);
  localparam logic [RW-1:0] LAST = RW'(READY_TICKS - 1);

  logic [RW-1:0] cnt_q;
  logic          rdy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else if (tick_i && !rdy_q) begin
      if (cnt_q == LAST) rdy_q <= 1'b1;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  assign ready_o = rdy_q;
endmodule

// File: rtl/pwrup_stage_ctrl.sv
module pwrup_stage_ctrl
  import pwrup_seq_pkg::*;
#(
  parameter int PWRT_TICKS = 16,
  parameter int OST_CYCLES = 1024,
  parameter int PLL_TICKS  = 64,
  parameter int CNT_W      = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              tick_i,
  input  logic              pwrt_en_ni,
  input  logic [MODE_W-1:0] osc_mode_i,
  output stage_e            stage_o
);
  localparam logic [CNT_W-1:0] PWRT_LAST = CNT_W'(PWRT_TICKS - 1);
  localparam logic [CNT_W-1:0] OST_LAST  = CNT_W'(OST_CYCLES - 1);
  localparam logic [CNT_W-1:0] PLL_LAST  = CNT_W'(PLL_TICKS - 1);

  stage_e           st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             xtal_q, pll_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      xtal_q <= 1'b0;
      pll_q  <= 1'b0;
    end else if (clr_i) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      xtal_q <= 1'b0;
      pll_q  <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          // configuration captured once per restart
          xtal_q <= mode_is_xtal(osc_mode_i);
          pll_q  <= mode_is_pll(osc_mode_i);
          cnt_q  <= '0;
          if (!pwrt_en_ni)                  st_q <= ST_PWRT;
          else if (mode_is_xtal(osc_mode_i)) st_q <= ST_OST;
          else                              st_q <= ST_DONE;
        end
        ST_PWRT: if (tick_i) begin
          if (cnt_q == PWRT_LAST) begin
            cnt_q <= '0;
            st_q  <= xtal_q ? ST_OST : ST_DONE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_OST: begin
          if (cnt_q == OST_LAST) begin
            cnt_q <= '0;
            st_q  <= pll_q ? ST_PLL : ST_DONE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_PLL: if (tick_i) begin
          if (cnt_q == PLL_LAST) begin
            cnt_q <= '0;
            st_q  <= ST_DONE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_DONE: st_q <= ST_DONE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign stage_o = st_q;
endmodule

// File: rtl/pwrup_rel_sync.sv
module pwrup_rel_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    sh_q <= '0;
        else if (clr_i) sh_q <= '0;
        else            sh_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    sh_q <= '0;
        else if (clr_i) sh_q <= '0;
        else            sh_q <= {sh_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/pwrup_seq.sv
module pwrup_seq
  import pwrup_seq_pkg::*;
#(
  parameter int PWRT_TICKS  = 16,
  parameter int OST_CYCLES  = 1024,
  parameter int PLL_TICKS   = 64,
  parameter int READY_TICKS = 4,
  parameter int SYNC_STAGES = 2,
  parameter int REL_STAGES  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_i,
  input  logic              ref_clk_i,
  input  logic              pwrt_en_ni,
  input  logic [MODE_W-1:0] osc_mode_i,
  output logic              dev_rst_no,
  output logic [2:0]        stage_o
);
  localparam int MAX_A   = (PWRT_TICKS > OST_CYCLES) ? PWRT_TICKS : OST_CYCLES;
  localparam int MAX_CNT = (MAX_A > PLL_TICKS) ? MAX_A : PLL_TICKS;
  localparam int CNT_W   = $clog2(MAX_CNT + 1);

  logic   tick;
  logic   ready;
  stage_e stage;

  pwrup_ref_tick #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ref_clk_i (ref_clk_i),
    .tick_o    (tick)
  );

  pwrup_ready_timer #(.READY_TICKS(READY_TICKS)) u_ready (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (por_i),
    .tick_i  (tick),
    .ready_o (ready)
  );

  pwrup_stage_ctrl #(
    .PWRT_TICKS (PWRT_TICKS),
    .OST_CYCLES (OST_CYCLES),
    .PLL_TICKS  (PLL_TICKS),
    .CNT_W      (CNT_W)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (por_i),
    .tick_i     (tick),
    .pwrt_en_ni (pwrt_en_ni),
    .osc_mode_i (osc_mode_i),
    .stage_o    (stage)
  );

  pwrup_rel_sync #(.STAGES(REL_STAGES)) u_rel (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (por_i),
    .d_i    ((stage == ST_DONE) && ready),
    .q_o    (dev_rst_no)
  );

  assign stage_o = stage;
endmodule

// File: rtl/pwrup_seq_chk.sv
module pwrup_seq_chk
  import pwrup_seq_pkg::*;
#(
  parameter int OST_CYCLES = 1024
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              por_i,
  input logic [MODE_W-1:0] osc_mode_i,
  input logic              dev_rst_no,
  input logic [2:0]        stage_o
);
  int ost_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                ost_run <= 0;
    else if (stage_o == ST_OST) ost_run <= ost_run + 1;
    else                        ost_run <= 0;
  end

  a_r1_legal_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stage_o <= 3'd4);

  a_r9_por_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_i |=> (stage_o == ST_IDLE && !dev_rst_no));

  a_r8_release_needs_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_rst_no |-> stage_o == ST_DONE);

  a_r8_release_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_rst_no && !por_i) |=> dev_rst_no);

  a_r4_ost_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stage_o != ST_OST && $past(stage_o) == ST_OST && !$past(por_i))
      |-> ost_run == OST_CYCLES);

  a_r4_ost_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stage_o == ST_OST && $past(stage_o) != ST_OST)
      |-> ($past(stage_o) == ST_IDLE || $past(stage_o) == ST_PWRT));

  a_r6_ost_only_xtal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stage_o == ST_OST && $past(stage_o) == ST_IDLE) |-> $past(osc_mode_i) <= 3'd3);

  a_r5_pll_after_ost: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stage_o == ST_PLL && $past(stage_o) != ST_PLL) |-> $past(stage_o) == ST_OST);
endmodule

bind pwrup_seq pwrup_seq_chk #(.OST_CYCLES(OST_CYCLES)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .por_i      (por_i),
  .osc_mode_i (osc_mode_i),
  .dev_rst_no (dev_rst_no),
  .stage_o    (stage_o)
);

// File: tb/pwrup_seq_test.sv
`timescale 1ns/1ps
module pwrup_seq_test;
  localparam int PWRT_TICKS  = 16;
  localparam int OST_CYCLES  = 1024;
  localparam int PLL_TICKS   = 64;
  localparam int READY_TICKS = 4;
  localparam int REF_HALF    = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       por = 1'b0;
  logic       ref_clk = 1'b0;
  logic       pwrt_en_n = 1'b0;
  logic [2:0] mode = 3'd2;
  logic       dev_rst_n;
  logic [2:0] stage;

  int n_tests = 0;
  int n_fail  = 0;
  int wd      = 0;
  int cin[5];
  int done_cyc, rel_cyc;

  always #4 clk = ~clk;

  pwrup_seq uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .por_i      (por),
    .ref_clk_i  (ref_clk),
    .pwrt_en_ni (pwrt_en_n),
    .osc_mode_i (mode),
    .dev_rst_no (dev_rst_n),
    .stage_o    (stage)
  );

  int ref_div = 0;
  always @(negedge clk) begin
    ref_div = ref_div + 1;
    if (ref_div == REF_HALF) begin
      ref_div = 0;
      ref_clk <= ~ref_clk;
    end
  end

  // behavioural reference model
  bit h1, h2, h3, m_ready, m_rel1, m_rel2, m_xtal, m_pll, tk, nrel;
  int m_state, m_cnt, m_rcnt;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h1 = 0; h2 = 0; h3 = 0; m_ready = 0; m_rel1 = 0; m_rel2 = 0;
      m_xtal = 0; m_pll = 0; m_state = 0; m_cnt = 0; m_rcnt = 0;
    end else begin
      tk = h2 && !h3;
      h3 = h2; h2 = h1; h1 = ref_clk;
      nrel = (m_state == 4) && m_ready;
      if (por) begin
        m_state = 0; m_cnt = 0; m_rcnt = 0; m_ready = 0;
        m_rel1 = 0; m_rel2 = 0; m_xtal = 0; m_pll = 0;
      end else begin
        m_rel2 = m_rel1; m_rel1 = nrel;
        if (tk && !m_ready) begin
          if (m_rcnt == READY_TICKS - 1) m_ready = 1;
          else m_rcnt++;
        end
        case (m_state)
          0: begin
            m_xtal = (mode < 4); m_pll = (mode == 3); m_cnt = 0;
            m_state = !pwrt_en_n ? 1 : (m_xtal ? 2 : 4);
          end
          1: if (tk) begin
            m_cnt++;
            if (m_cnt == PWRT_TICKS) begin m_cnt = 0; m_state = m_xtal ? 2 : 4; end
          end
          2: begin
            m_cnt++;
            if (m_cnt == OST_CYCLES) begin m_cnt = 0; m_state = m_pll ? 3 : 4; end
          end
          3: if (tk) begin
            m_cnt++;
            if (m_cnt == PLL_TICKS) begin m_cnt = 0; m_state = 4; end
          end
          default: m_state = 4;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    n_tests++;
    if (stage !== m_state[2:0] || dev_rst_n !== m_rel2) begin
      n_fail++;
      $display("FAIL model R2 R3 R4 R5 R6 R7 R8: stage=%0d rst=%0b expected stage=%0d rst=%0b",
               stage, dev_rst_n, m_state, m_rel2);
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      n_fail++;
      $display("FAIL watchdog: cycles=%0d expected below 100000", wd);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_por();
    @(negedge clk); por = 1'b1;
    @(negedge clk); por = 1'b0;
  endtask

  task automatic run_seq(input int flip_at, input int limit);
    for (int i = 0; i < 5; i++) cin[i] = 0;
    done_cyc = -1; rel_cyc = -1;
    for (int c = 1; c <= limit; c++) begin
      @(negedge clk);
      cin[stage]++;
      if (stage == 3'd4 && done_cyc < 0) done_cyc = c;
      if (dev_rst_n) begin rel_cyc = c; break; end
      if (c == flip_at) begin mode = 3'd5; pwrt_en_n = 1'b1; end
    end
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(stage == 3'd0, "R1 stage in reset", stage, 0);
    chk(dev_rst_n == 1'b0, "R1 reset out in reset", dev_rst_n, 0);
    mode = 3'd2; pwrt_en_n = 1'b0;
    rst_n = 1'b1;

    // HS, mode/enable flipped mid-run (R2, R4, R8)
    run_seq(50, 5000);
    chk(cin[1] > 0, "R2 power-up stage kept after flip", cin[1], 1);
    chk(cin[2] == OST_CYCLES, "R4 start-up length HS", cin[2], OST_CYCLES);
    chk(cin[3] == 0, "R5 no PLL stage in HS", cin[3], 0);
    chk(rel_cyc == done_cyc + 2, "R8 release two cycles after done", rel_cyc, done_cyc + 2);
    repeat (20) @(negedge clk);
    chk(dev_rst_n == 1'b1, "R8 release held", dev_rst_n, 1);

    // HS+PLL with power-up timer (R3, R5, R9)
    mode = 3'd3; pwrt_en_n = 1'b0;
    pulse_por();
    chk(stage == 3'd0 && !dev_rst_n, "R9 por clears after release", {stage, dev_rst_n}, 0);
    run_seq(0, 5000);
    chk(cin[1] >= (PWRT_TICKS-1)*2*REF_HALF+1 && cin[1] <= PWRT_TICKS*2*REF_HALF,
        "R3 power-up length", cin[1], PWRT_TICKS*2*REF_HALF);
    chk(cin[2] == OST_CYCLES, "R4 start-up length PLL mode", cin[2], OST_CYCLES);
    chk(cin[3] >= (PLL_TICKS-1)*2*REF_HALF+1 && cin[3] <= PLL_TICKS*2*REF_HALF,
        "R5 PLL wait length", cin[3], PLL_TICKS*2*REF_HALF);
    chk(rel_cyc == done_cyc + 2, "R8 release after PLL", rel_cyc, done_cyc + 2);

    // external clock, timer disabled (R6, R7)
    mode = 3'd4; pwrt_en_n = 1'b1;
    pulse_por();
    run_seq(0, 500);
    chk(cin[1] == 0 && cin[2] == 0 && cin[3] == 0, "R6 no stages in EC", cin[1]+cin[2]+cin[3], 0);
    chk(done_cyc == 1, "R6 done one cycle after restart", done_cyc, 1);
    chk(rel_cyc >= (READY_TICKS-1)*2*REF_HALF+3 && rel_cyc <= READY_TICKS*2*REF_HALF+2,
        "R7 ready delay gates release", rel_cyc, READY_TICKS*2*REF_HALF);

    // internal oscillator with timer (R6)
    mode = 3'd6; pwrt_en_n = 1'b0;
    pulse_por();
    run_seq(0, 2000);
    chk(cin[1] > 0 && cin[2] == 0 && cin[3] == 0, "R6 timer only in INTOSC", cin[2]+cin[3], 0);

    // restart mid start-up count (R9)
    mode = 3'd1; pwrt_en_n = 1'b1;
    pulse_por();
    repeat (300) @(negedge clk);
    chk(stage == 3'd2, "R4 in start-up count", stage, 2);
    pulse_por();
    chk(stage == 3'd0 && !dev_rst_n, "R9 por mid start-up", {stage, dev_rst_n}, 0);
    run_seq(0, 3000);
    chk(cin[2] == OST_CYCLES, "R9 full start-up after restart", cin[2], OST_CYCLES);

    // LP crystal with timer (R4)
    mode = 3'd0; pwrt_en_n = 1'b0;
    pulse_por();
    run_seq(0, 3000);
    chk(cin[2] == OST_CYCLES && cin[3] == 0, "R4 LP start-up", cin[2], OST_CYCLES);
    chk(rel_cyc > 0, "R8 LP released", rel_cyc, 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule